// File: doc/BRIEF.md
# Timer-Triggered Configuration Sequencer

This block is the control core of an ultra-low-power sensing node. It has no processor. A bank of down-counting wake-up timers starts all activity. When a timer runs out, a short chain of configuration words is played out to a datapath. These words come from a small setup store. Each word drives a set of control lines and power-enable lines. The chain moves on to its next word only when the datapath reports that the current step is done. When nothing is running, every control line and power line is held low, so the datapath draws no power.

Each timer keeps two reload periods. Normally a channel runs at its normal rate. A rate bit can switch it to the alternate rate, for example to sample faster while something interesting is going on. A hold bit uses the alternate period once, as a single long delay, and then the channel goes back to its normal rate by itself.

The setup store holds one group of words for each energy mode. A mode register selects the group, and the mode is captured when a sequence starts. If several timers fire together, the lowest-numbered timer goes first. The others wait as pending until the sequencer is free. Software programs everything through a single write-only register port.

Top module: `wake_seq`

## Requirements
- R1: A sequence starts (seq_busy_o rises) only after a timer expiry. While every timer is disabled, the block stays idle, and pulses on step_done_i have no effect.
- R2: Writing P to the normal period of timer t (address 0x00+t) and then writing 1 to its control register (address 0x40+t, bit 0 = enable) restarts the count. seq_busy_o rises P+1 cycles after that control write, and then every P cycles.
- R3: Setting control bit 1 (alternate rate) makes timer t reload from its alternate period, written at address 0x20+t. Starts then come every alternate period.
- R4: Setting control bit 2 (hold) together with enable gives exactly one interval of the alternate period. After it, the timer reloads from its normal period and stays at the normal rate.
- R5: Writing a period register does not disturb the count in progress. The new value takes effect at that timer's next reload.
- R6: While busy, dp_ctrl_o and dp_pwr_o show the setup word for the captured bank, the timer being served and the current step. The word is written at 0x80 + bank*16 + timer*4 + step. Word bits [7:0] are the control lines, bits [15:8] are the power enables, and bit 16 is the last-step flag. Every sequence begins at step 0.
- R7: The step index advances by one only in a cycle where step_done_i is high. Otherwise the step index and the outputs hold.
- R8: A done on a word whose last-step flag is set ends the sequence. A done on step 3 (the final index) also ends it, whatever the flag says.
- R9: When more than one timer is pending at a start, the lowest-numbered timer is served. The others stay pending and are served in later sequences.
- R10: The bank is set by the mode register (address 0x60, value = bank number) and is captured when a sequence starts. A mode write during a sequence affects only later sequences.
- R11: After reset, and whenever the block is idle, dp_ctrl_o and dp_pwr_o are all zero and seq_busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 17 | Register write data |
| step_done_i | input | 1 | Datapath step-complete indication |
| dp_ctrl_o | output | 8 | Datapath control lines |
| dp_pwr_o | output | 8 | Datapath power enables |
| seq_busy_o | output | 1 | A sequence is being played |
| seq_timer_o | output | 2 | Timer whose sequence is playing |
| seq_step_o | output | 2 | Current step index |

## Verification
The assertions assume that step_done_i is meaningful only while the block is busy. They treat it as a per-cycle advance request. They do not require it to be a single-cycle pulse.

The assertions also assume that register writes never fall in the same cycle as a sequence start. The bench keeps to this by using periods of at least six cycles, one-cycle sequences when the datapath answer is automatic, and mode writes placed well away from timer starts.

The bench drives step_done_i while idle on purpose, to show that it is ignored there. Random period values and random setup-word contents are drawn from a seeded generator.

// File: rtl/wake_seq_pkg.sv
package wake_seq_pkg;

    // Register kinds selected by the two address bits below the store flag.
    typedef enum logic [1:0] {
        REG_PER_NORM = 2'd0,
        REG_PER_ALT  = 2'd1,
        REG_CTRL     = 2'd2,
        REG_MODE     = 2'd3
    } reg_kind_e;

    // Bit positions inside a timer control write.
    localparam int CTL_EN   = 0;
    localparam int CTL_ALT  = 1;
    localparam int CTL_HOLD = 2;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

endpackage

// File: rtl/wake_seq_timer.sv
module wake_seq_timer
    import wake_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             norm_we_i,
    input  logic             alt_we_i,
    input  logic             ctl_we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] per_norm;
        logic [CNT_W-1:0] per_alt;
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             alt;
        logic             hold;
    } tmr_t;

    tmr_t q, d;

    function automatic logic [CNT_W-1:0] reload(input logic [CNT_W-1:0] p);
        return (p == '0) ? '0 : p - 1'b1;
    endfunction

    always_comb begin
        d        = q;
        expire_o = q.en && (q.cnt == '0);
        if (q.en) begin
            if (expire_o) begin
                if (q.hold) begin
                    // single long interval finished: back to the normal rate
                    d.hold = 1'b0;
                    d.alt  = 1'b0;
                    d.cnt  = reload(q.per_norm);
                end else begin
                    d.cnt = reload(q.alt ? q.per_alt : q.per_norm);
                end
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
        if (norm_we_i) d.per_norm = wdata_i;
        if (alt_we_i)  d.per_alt  = wdata_i;
        if (ctl_we_i) begin
            d.en   = wdata_i[CTL_EN];
            d.alt  = wdata_i[CTL_ALT];
            d.hold = wdata_i[CTL_HOLD];
            d.cnt  = reload((wdata_i[CTL_HOLD] || wdata_i[CTL_ALT]) ? q.per_alt : q.per_norm);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/wake_seq_store.sv
module wake_seq_store #(
    parameter int NUM_BANKS = 2,
    parameter int NUM_TMR   = 4,
    parameter int STEPS     = 4,
    parameter int WORD_W    = 17,
    parameter int IDX_W     = 5,
    parameter int BANK_W    = 1,
    parameter int TMR_W     = 2,
    parameter int STEP_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [TMR_W-1:0]  tmr_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int DEPTH = NUM_BANKS * NUM_TMR * STEPS;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [WORD_W-1:0] mem_d [DEPTH];

    always_comb begin
        int rd_i;
        mem_d = mem_q;
        if (we_i && (int'(widx_i) < DEPTH)) mem_d[widx_i] = wdata_i;
        rd_i   = int'(bank_i) * (NUM_TMR * STEPS) + int'(tmr_i) * STEPS + int'(step_i);
        word_o = mem_q[IDX_W'(rd_i)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/wake_seq_ctrl.sv
module wake_seq_ctrl
    import wake_seq_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int STEPS   = 4,
    parameter int TMR_W   = 2,
    parameter int STEP_W  = 2,
    parameter int BANK_W  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire_i,
    input  logic               done_i,
    input  logic               last_i,
    input  logic [BANK_W-1:0]  mode_i,
    output logic               busy_o,
    output logic [TMR_W-1:0]   tmr_o,
    output logic [STEP_W-1:0]  step_o,
    output logic [BANK_W-1:0]  bank_o,
    output logic [NUM_TMR-1:0] pend_o
);

    typedef struct packed {
        sq_state_e          state;
        logic [NUM_TMR-1:0] pend;
        logic [TMR_W-1:0]   tmr;
        logic [STEP_W-1:0]  step;
        logic [BANK_W-1:0]  bank;
    } seq_t;

    seq_t q, d;
    logic [NUM_TMR-1:0] grant;
    logic [TMR_W-1:0]   sel;

    always_comb begin
        d     = q;
        grant = '0;
        sel   = '0;
        for (int i = NUM_TMR - 1; i >= 0; i--) begin
            if (q.pend[i]) sel = TMR_W'(i);
        end
        case (q.state)
            SQ_IDLE: begin
                if (|q.pend) begin
                    grant[sel] = 1'b1;
                    d.state    = SQ_RUN;
                    d.tmr      = sel;
                    d.step     = '0;
                    d.bank     = mode_i;
                end
            end
            default: begin
                if (done_i) begin
                    if (last_i || (q.step == STEP_W'(STEPS - 1))) d.state = SQ_IDLE;
                    else                                          d.step  = q.step + 1'b1;
                end
            end
        endcase
        d.pend = (q.pend & ~grant) | expire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.state == SQ_RUN);
    assign tmr_o  = q.tmr;
    assign step_o = q.step;
    assign bank_o = q.bank;
    assign pend_o = q.pend;

endmodule

// File: rtl/wake_seq.sv
module wake_seq
    import wake_seq_pkg::*;
#(
    parameter int NUM_TMR   = 4,
    parameter int CNT_W     = 16,
    parameter int NUM_BANKS = 2,
    parameter int STEPS     = 4,
    parameter int CTRL_W    = 8,
    parameter int PWR_W     = 8,
    parameter int ADDR_W    = 8,
    localparam int WORD_W   = CTRL_W + PWR_W + 1,
    localparam int DATA_W   = (WORD_W > CNT_W) ? WORD_W : CNT_W,
    localparam int TMR_W    = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
    localparam int STEP_W   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              step_done_i,
    output logic [CTRL_W-1:0] dp_ctrl_o,
    output logic [PWR_W-1:0]  dp_pwr_o,
    output logic              seq_busy_o,
    output logic [TMR_W-1:0]  seq_timer_o,
    output logic [STEP_W-1:0] seq_step_o
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int DEPTH  = NUM_BANKS * NUM_TMR * STEPS;
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [BANK_W-1:0] mode;
    } top_t;

    top_t top_q, top_d;

    logic [NUM_TMR-1:0] norm_we, alt_we, ctl_we;
    logic [NUM_TMR-1:0] expire_w, pend_w;
    logic               mem_we;
    reg_kind_e          kind;
    logic [TMR_W-1:0]   tsel;
    logic [BANK_W-1:0]  run_bank;
    logic [WORD_W-1:0]  word;
    logic               word_last;

    // address decode and mode register
    always_comb begin
        top_d   = top_q;
        norm_we = '0;
        alt_we  = '0;
        ctl_we  = '0;
        mem_we  = cfg_we && cfg_addr[ADDR_W-1];
        kind    = reg_kind_e'(cfg_addr[ADDR_W-2 -: 2]);
        tsel    = cfg_addr[TMR_W-1:0];
        if (cfg_we && !cfg_addr[ADDR_W-1]) begin
            case (kind)
                REG_PER_NORM: if (int'(tsel) < NUM_TMR) norm_we[tsel] = 1'b1;
                REG_PER_ALT:  if (int'(tsel) < NUM_TMR) alt_we[tsel]  = 1'b1;
                REG_CTRL:     if (int'(tsel) < NUM_TMR) ctl_we[tsel]  = 1'b1;
                default: begin
                    if (int'(cfg_wdata[BANK_W-1:0]) < NUM_BANKS) top_d.mode = cfg_wdata[BANK_W-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        wake_seq_timer #(
            .CNT_W(CNT_W)
        ) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .norm_we_i(norm_we[g]),
            .alt_we_i (alt_we[g]),
            .ctl_we_i (ctl_we[g]),
            .wdata_i  (cfg_wdata[CNT_W-1:0]),
            .expire_o (expire_w[g])
        );
    end

    wake_seq_store #(
        .NUM_BANKS(NUM_BANKS),
        .NUM_TMR  (NUM_TMR),
        .STEPS    (STEPS),
        .WORD_W   (WORD_W),
        .IDX_W    (IDX_W),
        .BANK_W   (BANK_W),
        .TMR_W    (TMR_W),
        .STEP_W   (STEP_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mem_we),
        .widx_i (cfg_addr[IDX_W-1:0]),
        .wdata_i(cfg_wdata[WORD_W-1:0]),
        .bank_i (run_bank),
        .tmr_i  (seq_timer_o),
        .step_i (seq_step_o),
        .word_o (word)
    );

    wake_seq_ctrl #(
        .NUM_TMR(NUM_TMR),
        .STEPS  (STEPS),
        .TMR_W  (TMR_W),
        .STEP_W (STEP_W),
        .BANK_W (BANK_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire_i(expire_w),
        .done_i  (step_done_i),
        .last_i  (word_last),
        .mode_i  (top_q.mode),
        .busy_o  (seq_busy_o),
        .tmr_o   (seq_timer_o),
        .step_o  (seq_step_o),
        .bank_o  (run_bank),
        .pend_o  (pend_w)
    );

    always_comb begin
        word_last = word[WORD_W-1];
        dp_ctrl_o = seq_busy_o ? word[CTRL_W-1:0] : '0;
        dp_pwr_o  = seq_busy_o ? word[CTRL_W +: PWR_W] : '0;
    end

endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
    parameter int NUM_TMR = 4,
    parameter int STEPS   = 4,
    parameter int CTRL_W  = 8,
    parameter int PWR_W   = 8,
    localparam int TMR_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic [TMR_W-1:0]   tmr,
    input logic [STEP_W-1:0]  step,
    input logic               done,
    input logic               last,
    input logic [NUM_TMR-1:0] pend,
    input logic [CTRL_W-1:0]  ctrl,
    input logic [PWR_W-1:0]   pwr
);

    logic [NUM_TMR-1:0] pick_mask, low_mask;

    always_comb begin
        pick_mask      = '0;
        pick_mask[tmr] = 1'b1;
        low_mask       = pick_mask - 1'b1;
    end

    AST_START_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (($past(pend) & pick_mask) != '0)); // R1

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (($past(pend) & low_mask) == '0)); // R9

    AST_START_AT_STEP0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (step == '0)); // R6

    AST_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(step) && $stable(tmr))); // R7

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && !last && (step != STEP_W'(STEPS - 1))) |=>
            (busy && (step == STEP_W'($past(step) + 1'b1)))); // R7

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && (last || (step == STEP_W'(STEPS - 1)))) |=> !busy); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ((ctrl == '0) && (pwr == '0))); // R11

endmodule

bind wake_seq wake_seq_chk #(
    .NUM_TMR(NUM_TMR),
    .STEPS  (STEPS),
    .CTRL_W (CTRL_W),
    .PWR_W  (PWR_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .busy (seq_busy_o),
    .tmr  (seq_timer_o),
    .step (seq_step_o),
    .done (step_done_i),
    .last (word_last),
    .pend (pend_w),
    .ctrl (dp_ctrl_o),
    .pwr  (dp_pwr_o)
);

// File: tb/wake_seq_test.sv
module wake_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [16:0] cfg_wdata = '0;
    logic        done_man = 1'b0;
    logic        auto_done = 1'b0;
    logic        step_done;
    logic [7:0]  dp_ctrl, dp_pwr;
    logic        seq_busy;
    logic [1:0]  seq_timer, seq_step;

    int n_chk = 0, n_err = 0, cyc = 0, wr_cyc = 0;
    int nrise = 0, start_bank = 0, mode_shadow = 0;
    int rise_cyc [64];
    int rise_tmr [64];
    logic busy_prev = 1'b0;
    logic [16:0] shadow [2][4][4];

    always #10 clk = ~clk;

    assign step_done = auto_done ? seq_busy : done_man;

    wake_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .step_done_i(step_done),
        .dp_ctrl_o  (dp_ctrl),
        .dp_pwr_o   (dp_pwr),
        .seq_busy_o (seq_busy),
        .seq_timer_o(seq_timer),
        .seq_step_o (seq_step)
    );

    function automatic int exp_outs(input int b, input int t, input int s);
        return int'(shadow[b][t][s][15:0]);
    endfunction

    function automatic logic [7:0] mem_addr(input int b, input int t, input int s);
        return 8'(128 + b * 16 + t * 4 + s);
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 17'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        wr_cyc = cyc;
        if (a == 8'h60) mode_shadow = d;
    endtask

    task automatic wait_rises(input int n, input int lim);
        for (int i = 0; i < lim && nrise < n; i++) @(negedge clk);
    endtask

    task automatic quiesce();
        for (int t = 0; t < 4; t++) wr(8'(8'h40 + t), 0);
        repeat (10) @(negedge clk);
        nrise = 0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            report();
            $finish;
        end
    end

    // output monitor: R6 while busy, R11 while idle
    always @(negedge clk) begin
        if (rst_n) begin
            if (seq_busy && !busy_prev) begin
                if (nrise < 64) begin
                    rise_cyc[nrise] = cyc;
                    rise_tmr[nrise] = int'(seq_timer);
                end
                nrise++;
                start_bank = mode_shadow;
            end
            if (seq_busy)
                chk({dp_pwr, dp_ctrl} == 16'(exp_outs(start_bank, int'(seq_timer), int'(seq_step))),
                    "R6", "word on outputs", int'({dp_pwr, dp_ctrl}),
                    exp_outs(start_bank, int'(seq_timer), int'(seq_step)));
            else
                chk({dp_pwr, dp_ctrl} == 16'h0, "R11", "idle outputs", int'({dp_pwr, dp_ctrl}), 0);
        end
        busy_prev = seq_busy;
    end

    initial begin
        int pa, pb, pn;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(seq_busy == 1'b0 && dp_ctrl == 8'h0 && dp_pwr == 8'h0, "R11", "reset state",
            int'({seq_busy, dp_pwr, dp_ctrl}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // random setup words; last flags: t0,t1 at step0, t2 at step2, t3 none
        for (int b = 0; b < 2; b++)
            for (int t = 0; t < 4; t++)
                for (int s = 0; s < 4; s++) begin
                    logic [16:0] w;
                    w = 17'($urandom);
                    w[16] = ((t < 2) && (s == 0)) || ((t == 2) && (s == 2));
                    shadow[b][t][s] = w;
                    wr(mem_addr(b, t, s), int'(w));
                end
        chk(seq_busy == 1'b0, "R1", "no start after store writes", int'(seq_busy), 0);
        auto_done = 1'b1;

        // R2: random normal periods
        for (int k = 0; k < 3; k++) begin
            pa = 6 + int'($urandom % 20);
            nrise = 0;
            wr(8'h00, pa);
            wr(8'h40, 1);
            wait_rises(4, 4 * pa + 20);
            chk(nrise >= 4, "R2", "start count", nrise, 4);
            chk(rise_cyc[0] - wr_cyc == pa + 1, "R2", "first start delay", rise_cyc[0] - wr_cyc, pa + 1);
            for (int i = 0; i < 3; i++)
                chk(rise_cyc[i + 1] - rise_cyc[i] == pa, "R2", "interval", rise_cyc[i + 1] - rise_cyc[i], pa);
            chk(rise_tmr[0] == 0, "R2", "timer served", rise_tmr[0], 0);
            quiesce();
        end

        // R3: alternate rate
        pa = 8 + int'($urandom % 8);
        pb = 20 + int'($urandom % 10);
        wr(8'h00, pa);
        wr(8'h20, pb);
        nrise = 0;
        wr(8'h40, 3);
        wait_rises(3, 4 * pb);
        chk(rise_cyc[0] - wr_cyc == pb + 1, "R3", "first alt start", rise_cyc[0] - wr_cyc, pb + 1);
        for (int i = 0; i < 2; i++)
            chk(rise_cyc[i + 1] - rise_cyc[i] == pb, "R3", "alt interval", rise_cyc[i + 1] - rise_cyc[i], pb);
        quiesce();

        // R4: one long hold interval, then normal rate
        nrise = 0;
        wr(8'h40, 5);
        wait_rises(4, 2 * pb + 4 * pa);
        chk(rise_cyc[0] - wr_cyc == pb + 1, "R4", "long first interval", rise_cyc[0] - wr_cyc, pb + 1);
        for (int i = 0; i < 3; i++)
            chk(rise_cyc[i + 1] - rise_cyc[i] == pa, "R4", "normal after hold", rise_cyc[i + 1] - rise_cyc[i], pa);
        quiesce();

        // R5: period write does not restart the count
        pa = 8 + int'($urandom % 8);
        pn = 16 + int'($urandom % 10);
        wr(8'h00, pa);
        nrise = 0;
        wr(8'h40, 1);
        wait_rises(1, pa + 10);
        repeat (2) @(negedge clk);
        wr(8'h00, pn);
        wait_rises(3, pa + 2 * pn + 10);
        chk(rise_cyc[1] - rise_cyc[0] == pa, "R5", "old period kept", rise_cyc[1] - rise_cyc[0], pa);
        chk(rise_cyc[2] - rise_cyc[1] == pn, "R5", "new period at reload", rise_cyc[2] - rise_cyc[1], pn);
        quiesce();

        // R9: timers 0 and 1 expire in the same cycle
        wr(8'h00, 12);
        wr(8'h01, 14);
        nrise = 0;
        wr(8'h41, 1);
        wr(8'h40, 1);
        wait_rises(2, 40);
        chk(rise_tmr[0] == 0, "R9", "lower timer first", rise_tmr[0], 0);
        chk(rise_tmr[1] == 1, "R9", "other timer served next", rise_tmr[1], 1);
        chk(rise_cyc[1] - rise_cyc[0] == 2, "R9", "pending served when idle", rise_cyc[1] - rise_cyc[0], 2);
        quiesce();

        // R7 R8 R10: multi-step sequence with manual done
        auto_done = 1'b0;
        done_man = 1'b0;
        wr(8'h02, 300);
        wr(8'h42, 1);
        wait_rises(1, 400);
        wr(8'h42, 0);
        chk(seq_busy && seq_step == 2'd0 && seq_timer == 2'd2, "R7", "start step",
            int'({seq_timer, seq_step}), 8);
        repeat (3) @(negedge clk);
        chk(seq_busy && seq_step == 2'd0, "R7", "hold without done", int'(seq_step), 0);
        done_man = 1'b1;
        @(negedge clk);
        done_man = 1'b0;
        chk(seq_step == 2'd1, "R7", "advance on done", int'(seq_step), 1);
        wr(8'h60, 1);
        chk(seq_busy && seq_step == 2'd1, "R7", "hold after mode write", int'(seq_step), 1);
        chk(int'({dp_pwr, dp_ctrl}) == exp_outs(0, 2, 1), "R10", "bank kept mid-sequence",
            int'({dp_pwr, dp_ctrl}), exp_outs(0, 2, 1));
        done_man = 1'b1;
        @(negedge clk);
        done_man = 1'b0;
        chk(seq_step == 2'd2, "R7", "second advance", int'(seq_step), 2);
        done_man = 1'b1;
        @(negedge clk);
        done_man = 1'b0;
        chk(seq_busy == 1'b0, "R8", "last flag ends", int'(seq_busy), 0);

        // R8 R10: timer 3 has no last flag; runs all four steps from bank 1
        auto_done = 1'b1;
        nrise = 0;
        wr(8'h03, 30);
        wr(8'h43, 1);
        for (int i = 0; i < 60 && !seq_busy; i++) @(negedge clk);
        chk(int'({dp_pwr, dp_ctrl}) == exp_outs(1, 3, 0), "R10", "new bank used",
            int'({dp_pwr, dp_ctrl}), exp_outs(1, 3, 0));
        begin
            int len;
            len = 0;
            while (seq_busy && len < 10) begin
                len++;
                @(negedge clk);
            end
            chk(len == 4, "R8", "final index ends", len, 4);
        end
        quiesce();

        // R1: idle with all timers off, done pulses ignored
        auto_done = 1'b0;
        for (int i = 0; i < 4; i++) begin
            done_man = 1'b1;
            @(negedge clk);
            done_man = 1'b0;
            repeat (5) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        chk(nrise == 0 && !seq_busy, "R1", "no start without expiry", nrise, 0);
        chk(dp_ctrl == 8'h0 && dp_pwr == 8'h0, "R1", "outputs stay low", int'({dp_pwr, dp_ctrl}), 0);

        report();
        $finish;
    end

endmodule